// File: doc/BRIEF.md
# Bus Hold Handshake Controller

This block lives in a processor's bus interface unit and decides when the shared address, data and control bus can be handed to an external master, typically a DMA engine. The external master raises an active-high hold request. The block synchronizes that request and waits until the bus is at a safe point. A safe point means no bus cycle is part way through, no locked sequence is running and no interrupt-acknowledge pair is open. The block then raises its hold acknowledge and turns off the processor's bus drivers on the same clock edge.

While the bus is granted, the block stalls the processor's bus sequencer so that it starts no new cycle. The grant lasts for as long as the request stays high. When the external master drops the request, the block takes the bus back within a fixed number of clocks and needs no further handshake. A DMA master that moves one item per request can therefore pulse the request once per transfer.

Top module: `bus_hold_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it, `hold_ack_o` is 0 and all three output enables are 1, whatever level `hold_req_i` has.
- R2: `hold_req_i` is active high and passes through a two-stage synchronizer. With the bus idle (`bus_phase_i` = 2'b00) and no lock or interrupt-acknowledge pair, `hold_ack_o` rises on the third rising clock edge after the request is first sampled high.
- R3: The grant is never given part way through a bus cycle. The decision edge must follow a cycle whose `bus_phase_i` was 2'b00 (idle) or 2'b11 (last clock of a bus cycle). The phase values 2'b01 (address) and 2'b10 (data) block the grant.
- R4: The output enables `addr_oe_o`, `data_oe_o` and `ctrl_oe_o` are the inverse of `hold_ack_o` and change on the same edge as it.
- R5: No grant is given while `lock_i` is 1. A pending request is granted on the edge after the lock is released at a bus boundary.
- R6: No grant is given while `inta_pair_i` is 1. This covers the idle gap between the two acknowledge cycles.
- R7: After `hold_req_i` falls, `hold_ack_o` falls, and the drivers come back on, at the third rising edge. No more than three clocks are spent granted with the request low.
- R8: Once granted, the acknowledge stays high for as long as the synchronized request stays high.
- R9: `cycle_stall_o` is 1 whenever `hold_ack_o` is 1. It is also 1 while a synchronized request is pending with neither lock nor interrupt-acknowledge pair active. Otherwise it is 0.
- R10: Repeated short request pulses each produce a grant and a release with no other handshake. A one-clock pulse gives a one-clock grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hold_req_i | input | 1 | Asynchronous bus request from the external master |
| bus_phase_i | input | 2 | Sequencer phase: 00 idle, 01 address, 10 data, 11 last clock of cycle |
| lock_i | input | 1 | Locked bus sequence in progress |
| inta_pair_i | input | 1 | High from the start of the first interrupt-acknowledge cycle to the end of the second |
| hold_ack_o | output | 1 | Hold acknowledge to the external master |
| addr_oe_o | output | 1 | Address bus driver enable |
| data_oe_o | output | 1 | Data bus driver enable |
| ctrl_oe_o | output | 1 | Bus control driver enable |
| cycle_stall_o | output | 1 | Tells the sequencer to start no new bus cycle |

## Verification
The request is tried in five settings, and each one separates a different kind of fault.

- **Idle bus:** this fixes the three-clock synchronizer and grant latency.
- **Request raised in the address phase of a multi-clock cycle:** this shows whether the grant waits for the last clock or cuts into the data phase.
- **Two back-to-back locked cycles, and an interrupt-acknowledge pair with an idle gap between its cycles:** this exposes a grant that ignores either hold-off.
- **Trains of long and one-clock request pulses:** these check the release latency and the single-transfer hand-back.

Throughout all five settings, the driver enables and the stall output are compared against the acknowledge on every cycle.

// File: rtl/bus_hold_pkg.sv
package bus_hold_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'b00,
        PH_ADDR = 2'b01,
        PH_DATA = 2'b10,
        PH_LAST = 2'b11
    } bus_phase_e;

    typedef enum logic [1:0] {
        ST_OWN   = 2'b00,
        ST_WAIT  = 2'b01,
        ST_GRANT = 2'b10
    } hold_state_e;

    typedef struct packed {
        logic addr;
        logic data;
        logic ctrl;
    } bus_oe_t;

    localparam bus_oe_t OE_DRIVE = '{addr: 1'b1, data: 1'b1, ctrl: 1'b1};
    localparam bus_oe_t OE_FLOAT = '{addr: 1'b0, data: 1'b0, ctrl: 1'b0};

    function automatic logic at_boundary(bus_phase_e ph);
        return (ph == PH_IDLE) || (ph == PH_LAST);
    endfunction

endpackage

// File: rtl/hold_req_sync.sv
module hold_req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= async_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[STAGES-2:0], async_i};
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/hold_grant_gate.sv
module hold_grant_gate
    import bus_hold_pkg::*;
(
    input  logic       req_sync,
    input  bus_phase_e phase,
    input  logic       lock,
    input  logic       inta_pair,
    input  logic       ack_q,
    output logic       grant_ok,
    output logic       stall
);
    logic holdoff;

    always_comb begin
        holdoff  = lock | inta_pair;
        grant_ok = req_sync & at_boundary(phase) & ~holdoff;
        stall    = ack_q | (req_sync & ~holdoff);
    end
endmodule

// File: rtl/hold_ack_fsm.sv
module hold_ack_fsm
    import bus_hold_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    req_sync,
    input  logic    grant_ok,
    output logic    ack_q,
    output bus_oe_t oe_q
);
    hold_state_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_OWN, ST_WAIT: begin
                if (grant_ok)      st_d = ST_GRANT;
                else if (req_sync) st_d = ST_WAIT;
                else               st_d = ST_OWN;
            end
            ST_GRANT: if (!req_sync) st_d = ST_OWN;
            default:  st_d = ST_OWN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_OWN;
            ack_q <= 1'b0;
            oe_q  <= OE_DRIVE;
        end else begin
            st_q  <= st_d;
            ack_q <= (st_d == ST_GRANT);
            oe_q  <= (st_d == ST_GRANT) ? OE_FLOAT : OE_DRIVE;
        end
    end

    // R3: a rising acknowledge must follow a cleared grant condition
    assert_grant_needs_clear_bus_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(ack_q) |-> $past(grant_ok));

    // R8: the grant persists while the synchronized request is high
    assert_hold_while_requested_R8: assert property (@(posedge clk) disable iff (rst)
        (ack_q && req_sync) |=> ack_q);

    // R4: the drivers are off exactly while the acknowledge is high
    assert_drivers_off_R4: assert property (@(posedge clk) disable iff (rst)
        ack_q |-> (oe_q == OE_FLOAT));
    assert_drivers_on_R4: assert property (@(posedge clk) disable iff (rst)
        !ack_q |-> (oe_q == OE_DRIVE));
endmodule

// File: rtl/bus_hold_ctrl.sv
module bus_hold_ctrl
    import bus_hold_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       hold_req_i,
    input  logic [1:0] bus_phase_i,
    input  logic       lock_i,
    input  logic       inta_pair_i,
    output logic       hold_ack_o,
    output logic       addr_oe_o,
    output logic       data_oe_o,
    output logic       ctrl_oe_o,
    output logic       cycle_stall_o
);
    localparam int RELEASE_LAT = SYNC_STAGES + 1;
    localparam int RCNT_W      = $clog2(RELEASE_LAT + 2);

    bus_phase_e phase;
    logic       req_sync;
    logic       grant_ok;
    logic       ack_q;
    bus_oe_t    oe_q;

    assign phase = bus_phase_e'(bus_phase_i);

    hold_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (hold_req_i),
        .sync_o  (req_sync)
    );

    hold_grant_gate u_gate (
        .req_sync  (req_sync),
        .phase     (phase),
        .lock      (lock_i),
        .inta_pair (inta_pair_i),
        .ack_q     (ack_q),
        .grant_ok  (grant_ok),
        .stall     (cycle_stall_o)
    );

    hold_ack_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .req_sync (req_sync),
        .grant_ok (grant_ok),
        .ack_q    (ack_q),
        .oe_q     (oe_q)
    );

    assign hold_ack_o = ack_q;
    assign addr_oe_o  = oe_q.addr;
    assign data_oe_o  = oe_q.data;
    assign ctrl_oe_o  = oe_q.ctrl;

    // Counts clocks spent granted with the raw request already low
    logic [RCNT_W-1:0] rel_cnt_q;
    always_ff @(posedge clk) begin
        if (rst || !hold_ack_o || hold_req_i) rel_cnt_q <= '0;
        else if (rel_cnt_q != '1)              rel_cnt_q <= rel_cnt_q + 1'b1;
    end

    // R1: the processor owns the bus coming out of reset
    assert_reset_owns_bus_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!hold_ack_o && addr_oe_o && data_oe_o && ctrl_oe_o));

    // R3: no grant rises out of an address or data phase
    assert_no_midcycle_grant_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(hold_ack_o) |-> $past(at_boundary(phase)));

    // R5: no grant rises out of a locked sequence
    assert_no_grant_in_lock_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(hold_ack_o) |-> !$past(lock_i));

    // R6: no grant rises inside an interrupt-acknowledge pair
    assert_no_grant_in_inta_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(hold_ack_o) |-> !$past(inta_pair_i));

    // R4: acknowledge and bus drivers are never both active
    assert_no_drive_while_granted_R4: assert property (@(posedge clk) disable iff (rst)
        hold_ack_o |-> !(addr_oe_o || data_oe_o || ctrl_oe_o));

    // R9: the sequencer is stalled throughout a grant
    assert_stall_while_granted_R9: assert property (@(posedge clk) disable iff (rst)
        hold_ack_o |-> cycle_stall_o);

    // R7: release is bounded after the request falls
    assert_release_bounded_R7: assert property (@(posedge clk) disable iff (rst)
        rel_cnt_q <= RCNT_W'(RELEASE_LAT));
endmodule

// File: tb/bus_hold_ctrl_bench.sv
module bus_hold_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HIST       = 512;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hreq = 1'b0;
    logic [1:0] ph = 2'b00;
    logic       lock = 1'b0;
    logic       inta = 1'b0;
    logic       ack, a_oe, d_oe, c_oe, stall;

    int checks = 0;
    int errors = 0;
    int k = 0;
    bit done = 1'b0;

    bit h_req [HIST];
    bit h_ok  [HIST];
    bit h_ack [HIST];

    typedef struct {
        bit    ack;
        bit    stall;
        string tag;
    } exp_t;
    exp_t sbq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_hold_ctrl u_bus_hold_ctrl (
        .clk           (clk),
        .rst           (rst),
        .hold_req_i    (hreq),
        .bus_phase_i   (ph),
        .lock_i        (lock),
        .inta_pair_i   (inta),
        .hold_ack_o    (ack),
        .addr_oe_o     (a_oe),
        .data_oe_o     (d_oe),
        .ctrl_oe_o     (c_oe),
        .cycle_stall_o (stall)
    );

    task automatic chk(bit ok, string tag, string what, int got, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d at %0t", tag, what, got, exp, $time);
        end
    endtask

    function automatic bit req_at(int i);  return (i < 0) ? 1'b0 : h_req[i]; endfunction
    function automatic bit ok_at(int i);   return (i < 0) ? 1'b0 : h_ok[i];  endfunction
    function automatic bit ack_at(int i);  return (i < 0) ? 1'b0 : h_ack[i]; endfunction

    // Driver: applies one cycle of stimulus and queues the expected outputs.
    // The grant decision edge sees the request from three steps back (R2)
    // and the phase, lock and pair inputs from the step before it.
    task automatic step(bit r, logic [1:0] p, bit l, bit n, string tag);
        exp_t e;
        @(posedge clk); #1;
        hreq = r; ph = p; lock = l; inta = n;
        h_req[k] = r;
        h_ok[k]  = ((p == 2'b00) || (p == 2'b11)) && !l && !n;
        e.ack    = req_at(k-3) && (ack_at(k-1) || ok_at(k-1));
        h_ack[k] = e.ack;
        e.stall  = e.ack || (req_at(k-2) && !l && !n);
        e.tag    = tag;
        sbq.push_back(e);
        k++;
    endtask

    // Monitor: compares every queued item half a clock after the edge
    always @(negedge clk) begin
        if (!rst && sbq.size() > 0) begin
            exp_t e;
            e = sbq.pop_front();
            chk(ack === e.ack, e.tag, "hold_ack", int'(ack), int'(e.ack));
            chk({a_oe, d_oe, c_oe} === {3{!e.ack}}, "R4", "oe", int'({a_oe, d_oe, c_oe}),
                int'({3{!e.ack}}));
            chk(stall === e.stall, "R9", "stall", int'(stall), int'(e.stall));
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: request held high through reset must not be granted
        hreq = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(ack === 1'b0, "R1", "hold_ack in reset", int'(ack), 0);
            chk({a_oe, d_oe, c_oe} === 3'b111, "R1", "oe in reset", int'({a_oe, d_oe, c_oe}), 7);
        end
        @(posedge clk); #1; hreq = 1'b0;
        @(posedge clk); #1; rst = 1'b0;

        for (int i = 0; i < 3; i++) step(0, 2'b00, 0, 0, "R1");

        // R2 idle grant latency, R8 hold while requested, R7 release
        for (int i = 0; i < 4; i++) step(1, 2'b00, 0, 0, "R2");
        for (int i = 0; i < 6; i++) step(1, 2'b00, 0, 0, "R8");
        for (int i = 0; i < 5; i++) step(0, 2'b00, 0, 0, "R7");

        // R3: request raised in the address phase of a long cycle
        step(1, 2'b01, 0, 0, "R3");
        for (int i = 0; i < 4; i++) step(1, 2'b10, 0, 0, "R3");
        step(1, 2'b11, 0, 0, "R3");
        for (int i = 0; i < 4; i++) step(1, 2'b00, 0, 0, "R3");
        for (int i = 0; i < 5; i++) step(0, 2'b00, 0, 0, "R7");

        // R5: two locked cycles back to back, lock dropped after the second
        step(1, 2'b01, 1, 0, "R5");
        step(1, 2'b10, 1, 0, "R5");
        step(1, 2'b11, 1, 0, "R5");
        step(1, 2'b01, 1, 0, "R5");
        step(1, 2'b10, 1, 0, "R5");
        step(1, 2'b11, 1, 0, "R5");
        for (int i = 0; i < 4; i++) step(1, 2'b00, 0, 0, "R5");
        for (int i = 0; i < 5; i++) step(0, 2'b00, 0, 0, "R7");

        // R6: interrupt-acknowledge pair with idle clocks between its cycles
        step(1, 2'b01, 0, 1, "R6");
        step(1, 2'b10, 0, 1, "R6");
        step(1, 2'b11, 0, 1, "R6");
        step(1, 2'b00, 0, 1, "R6");
        step(1, 2'b00, 0, 1, "R6");
        step(1, 2'b01, 0, 1, "R6");
        step(1, 2'b10, 0, 1, "R6");
        step(1, 2'b11, 0, 1, "R6");
        for (int i = 0; i < 4; i++) step(1, 2'b00, 0, 0, "R6");
        for (int i = 0; i < 5; i++) step(0, 2'b00, 0, 0, "R7");

        // R10: single-transfer pulse trains, long and one-clock
        for (int t = 0; t < 3; t++) begin
            for (int i = 0; i < 4; i++) step(1, 2'b00, 0, 0, "R10");
            for (int i = 0; i < 4; i++) step(0, 2'b00, 0, 0, "R10");
        end
        for (int t = 0; t < 2; t++) begin
            step(1, 2'b00, 0, 0, "R10");
            for (int i = 0; i < 5; i++) step(0, 2'b00, 0, 0, "R10");
        end
        // processor resumes a bus cycle after the hand-back
        step(0, 2'b01, 0, 0, "R10");
        step(0, 2'b10, 0, 0, "R10");
        step(0, 2'b11, 0, 0, "R10");
        for (int i = 0; i < 3; i++) step(0, 2'b00, 0, 0, "R10");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule